// File: doc/BRIEF.md
# Exception Request Priority Arbiter

This block gathers the exception requests of a small CPU core and decides which one the exception sequencer services next, and when it does so. It handles five kinds of request: reset, trace, interrupt, direct transition and trap. Reset comes from the reset pin or from a watchdog overflow strobe, and it takes effect at once. Every other kind is weighed only at an instruction boundary. A boundary is either the retirement of an instruction or the sequencer's acknowledge that ends the handling of an exception.

The core reports each retiring instruction with a pulse and a two-bit class. The class can veto the trace check or the interrupt check on the boundary that follows. Trap and sleep-transition strobes may arrive at any time. They are latched until they are granted.

The grant goes to the sequencer as a valid flag, a one-hot selection and a vector index. The grant stays fixed until the sequencer pulses its acknowledge. Requests that lost the arbitration are weighed again at the boundary that the acknowledge creates.

Top module: `exc_arbiter`

## Requirements
- R1: When `res_n` is low or `wdt_ovf` is high in a cycle, the next cycle shows `gnt_valid`=1, `gnt_sel`=5'b00001 and `gnt_vec`=0. This replaces any active grant and clears the latched trap and sleep requests. While `res_n` is low, `gnt_ack` has no effect.
- R2: A grant that has been issued keeps `gnt_sel` and `gnt_vec` unchanged until `gnt_ack` is sampled high. The only exception is reset (R1).
- R3: A non-reset grant appears only in the cycle after a boundary. A boundary is `instr_done` sampled high while no grant is valid, or `gnt_ack` sampled high while a grant is valid. Latched requests wait without a grant until the next boundary.
- R4: At a boundary the winner is chosen in this order, from highest to lowest: trace, interrupt, direct transition, trap. Requests that are pending together are granted one after another, one per acknowledge.
- R5: Trace is a candidate only when `trace_en` is 1 and `int_mode` is 2 or 3. In modes 0 and 1 trace is ignored.
- R6: Trace is not a candidate at the boundary of an instruction of class 2'b01 (return from exception).
- R7: Interrupt (`irq_pend`) is not a candidate at the boundary of an instruction of class 2'b10 (condition or control register update). It is also not a candidate at the acknowledge that ends reset handling. Classes 2'b00 and 2'b11 veto nothing.
- R8: A `trap_exec` strobe is latched together with `trap_num` at any time, including while a grant is active. It stays pending until it is granted.
- R9: A `sleep_req` strobe is latched at any time and is granted as a direct transition.
- R10: The one-hot bits of `gnt_sel` are: bit0 reset, bit1 trace, bit2 interrupt, bit3 direct transition, bit4 trap. The vectors are: reset 0, trace 5, direct transition 6, interrupt 7, trap 8 plus `trap_num`.
- R11: After an acknowledge with no candidate left, `gnt_valid` drops to 0 and `gnt_sel` reads 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the flops |
| res_n | input | 1 | Reset pin, active low |
| wdt_ovf | input | 1 | Watchdog overflow strobe |
| trace_en | input | 1 | Trace bit of the core |
| irq_pend | input | 1 | Interrupt pending flag from the interrupt controller |
| sleep_req | input | 1 | Sleep-instruction direct-transition strobe |
| trap_exec | input | 1 | Trap instruction executed strobe |
| trap_num | input | TRAP_NUM_W | Trap number carried with the trap strobe |
| instr_done | input | 1 | Instruction retirement pulse |
| instr_cls | input | 2 | Class of the retiring instruction |
| int_mode | input | 2 | Interrupt control mode |
| gnt_ack | input | 1 | Sequencer acknowledge: handling of the grant is complete |
| gnt_valid | output | 1 | A grant is issued |
| gnt_sel | output | 5 | One-hot selected exception |
| gnt_vec | output | VEC_W | Vector index of the grant |

## Verification
The bench first checks that an acknowledge given while the reset pin is still low leaves reset in place. A design that let it through would start running under reset. The bench then checks that the acknowledge which ends reset does not grant a waiting interrupt. It drives all four boundary requests at once and checks that they drain in priority order, one per acknowledge. A wrong encoder would show up as a misordered vector. It checks the class vetoes and the trace mode gate, because a missing gate grants trace or interrupt one boundary too early. It checks that a watchdog strobe replaces an active grant and flushes a latched trap, so a design that failed to flush would re-grant the trap after reset.

// File: rtl/exc_arb_pkg.sv
package exc_arb_pkg;
   localparam int EXC_N      = 5;
   localparam int EXC_RESET  = 0;
   localparam int EXC_TRACE  = 1;
   localparam int EXC_IRQ    = 2;
   localparam int EXC_DTRANS = 3;
   localparam int EXC_TRAP   = 4;

   typedef enum logic [1:0] {
      ICLS_PLAIN = 2'b00,
      ICLS_RTE   = 2'b01,
      ICLS_CTRL  = 2'b10,
      ICLS_OTHER = 2'b11
   } instr_cls_e;
endpackage

// File: rtl/exc_prio_pick.sv
module exc_prio_pick #(
   parameter int unsigned N = 4
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] grant,
   output logic         any
);
   logic seen;

   always_comb begin
      seen  = 1'b0;
      grant = '0;
      for (int i = 0; i < int'(N); i++) begin
         grant[i] = req[i] & ~seen;
         seen     = seen | req[i];
      end
      any = seen;
   end
endmodule

// File: rtl/exc_pend_slot.sv
module exc_pend_slot #(
   parameter int unsigned DATA_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              set,
   input  logic [DATA_W-1:0] set_data,
   input  logic              drop,
   output logic              pend_nxt,
   output logic [DATA_W-1:0] data_nxt
);
   logic              pend_q;
   logic [DATA_W-1:0] data_q;
   logic              take;

   always_comb begin
      take     = set & (~pend_q | drop);
      pend_nxt = (pend_q & ~drop) | take;
      data_nxt = take ? set_data : data_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         data_q <= '0;
      end else if (flush) begin
         pend_q <= 1'b0;
      end else begin
         pend_q <= pend_nxt;
         data_q <= data_nxt;
      end
   end
endmodule

// File: rtl/exc_vec_enc.sv
module exc_vec_enc
   import exc_arb_pkg::*;
#(
   parameter int unsigned VEC_W         = 4,
   parameter int unsigned NUM_W         = 2,
   parameter int unsigned VEC_RESET     = 0,
   parameter int unsigned VEC_TRACE     = 5,
   parameter int unsigned VEC_DTRANS    = 6,
   parameter int unsigned VEC_IRQ       = 7,
   parameter int unsigned VEC_TRAP_BASE = 8
) (
   input  logic [EXC_N-1:0] sel,
   input  logic [NUM_W-1:0] num,
   output logic [VEC_W-1:0] vec
);
   always_comb begin
      vec = '0;
      if (sel[EXC_RESET])       vec = VEC_W'(VEC_RESET);
      else if (sel[EXC_TRACE])  vec = VEC_W'(VEC_TRACE);
      else if (sel[EXC_IRQ])    vec = VEC_W'(VEC_IRQ);
      else if (sel[EXC_DTRANS]) vec = VEC_W'(VEC_DTRANS);
      else if (sel[EXC_TRAP])   vec = VEC_W'(VEC_TRAP_BASE) + VEC_W'(num);
   end
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
   import exc_arb_pkg::*;
#(
   parameter int unsigned VEC_W         = 4,
   parameter int unsigned TRAP_NUM_W    = 2,
   parameter int unsigned VEC_RESET     = 0,
   parameter int unsigned VEC_TRACE     = 5,
   parameter int unsigned VEC_DTRANS    = 6,
   parameter int unsigned VEC_IRQ       = 7,
   parameter int unsigned VEC_TRAP_BASE = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  res_n,
   input  logic                  wdt_ovf,
   input  logic                  trace_en,
   input  logic                  irq_pend,
   input  logic                  sleep_req,
   input  logic                  trap_exec,
   input  logic [TRAP_NUM_W-1:0] trap_num,
   input  logic                  instr_done,
   input  logic [1:0]            instr_cls,
   input  logic [1:0]            int_mode,
   input  logic                  gnt_ack,
   output logic                  gnt_valid,
   output logic [EXC_N-1:0]      gnt_sel,
   output logic [VEC_W-1:0]      gnt_vec
);
   localparam int unsigned     CAND_N   = EXC_N - 1;
   localparam int unsigned     VEC_SPAN = 1 << VEC_W;
   localparam logic [EXC_N-1:0] RESET_OH = EXC_N'(1) << EXC_RESET;

   generate
      if (VEC_W < 1 || TRAP_NUM_W < 1) begin : g_bad_width
         $error("exc_arbiter: widths must be at least one bit");
      end
      if (VEC_TRAP_BASE + (1 << TRAP_NUM_W) > VEC_SPAN) begin : g_bad_trap
         $error("exc_arbiter: trap vectors exceed VEC_W");
      end
      if (VEC_RESET >= VEC_SPAN || VEC_TRACE >= VEC_SPAN ||
          VEC_DTRANS >= VEC_SPAN || VEC_IRQ >= VEC_SPAN) begin : g_bad_vec
         $error("exc_arbiter: a fixed vector exceeds VEC_W");
      end
   endgenerate

   logic                  rst_req, ack_ok, bnd_instr, bnd;
   logic                  drop_dt, drop_trap;
   logic                  dt_q, dt_nxt;
   logic                  trap_nxt;
   logic [TRAP_NUM_W-1:0] trap_num_nxt;
   logic                  trace_ok, irq_ok;
   logic [CAND_N-1:0]     cand, pick_oh;
   logic                  pick_any;
   logic [EXC_N-1:0]      nxt_sel;
   logic [VEC_W-1:0]      nxt_vec;

   always_comb begin
      rst_req   = ~res_n | wdt_ovf;
      ack_ok    = gnt_ack & gnt_valid & ~(gnt_sel[EXC_RESET] & ~res_n);
      bnd_instr = instr_done & ~gnt_valid;
      bnd       = bnd_instr | ack_ok;
      drop_dt   = ack_ok & gnt_sel[EXC_DTRANS];
      drop_trap = ack_ok & gnt_sel[EXC_TRAP];
      dt_nxt    = (dt_q & ~drop_dt) | sleep_req;
      trace_ok  = trace_en & (int_mode >= 2'd2)
                & ~(bnd_instr & (instr_cls == ICLS_RTE));
      irq_ok    = irq_pend
                & ~(bnd_instr & (instr_cls == ICLS_CTRL))
                & ~(ack_ok & gnt_sel[EXC_RESET]);
      cand      = {trap_nxt, dt_nxt, irq_ok, trace_ok};
      nxt_sel   = {pick_oh, 1'b0};
   end

   exc_pend_slot #(.DATA_W(TRAP_NUM_W)) trap_slot_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (rst_req),
      .set      (trap_exec),
      .set_data (trap_num),
      .drop     (drop_trap),
      .pend_nxt (trap_nxt),
      .data_nxt (trap_num_nxt)
   );

   exc_prio_pick #(.N(CAND_N)) pick_i (
      .req   (cand),
      .grant (pick_oh),
      .any   (pick_any)
   );

   exc_vec_enc #(
      .VEC_W        (VEC_W),
      .NUM_W        (TRAP_NUM_W),
      .VEC_RESET    (VEC_RESET),
      .VEC_TRACE    (VEC_TRACE),
      .VEC_DTRANS   (VEC_DTRANS),
      .VEC_IRQ      (VEC_IRQ),
      .VEC_TRAP_BASE(VEC_TRAP_BASE)
   ) enc_i (
      .sel (nxt_sel),
      .num (trap_num_nxt),
      .vec (nxt_vec)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gnt_valid <= 1'b1;
         gnt_sel   <= RESET_OH;
         gnt_vec   <= VEC_W'(VEC_RESET);
         dt_q      <= 1'b0;
      end else if (rst_req) begin
         gnt_valid <= 1'b1;
         gnt_sel   <= RESET_OH;
         gnt_vec   <= VEC_W'(VEC_RESET);
         dt_q      <= 1'b0;
      end else begin
         dt_q <= dt_nxt;
         if (bnd && pick_any) begin
            gnt_valid <= 1'b1;
            gnt_sel   <= nxt_sel;
            gnt_vec   <= nxt_vec;
         end else if (ack_ok) begin
            gnt_valid <= 1'b0;
            gnt_sel   <= '0;
            gnt_vec   <= '0;
         end
      end
   end
endmodule

// File: rtl/exc_arbiter_chk.sv
module exc_arbiter_chk
   import exc_arb_pkg::*;
#(
   parameter int unsigned VEC_W         = 4,
   parameter int unsigned VEC_RESET     = 0,
   parameter int unsigned VEC_TRAP_BASE = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             res_n,
   input logic             wdt_ovf,
   input logic             instr_done,
   input logic [1:0]       instr_cls,
   input logic [1:0]       int_mode,
   input logic             gnt_ack,
   input logic             gnt_valid,
   input logic [EXC_N-1:0] gnt_sel,
   input logic [VEC_W-1:0] gnt_vec
);
   logic quiet;
   assign quiet = res_n & ~wdt_ovf;

   assert_sel_coding_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_sel) && (gnt_valid == (gnt_sel != '0)));

   assert_reset_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!res_n || wdt_ovf) |=> gnt_valid && gnt_sel[EXC_RESET]
                              && gnt_vec == VEC_W'(VEC_RESET));

   assert_grant_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_valid && !gnt_ack && quiet) |=> $stable(gnt_sel) && $stable(gnt_vec));

   assert_boundary_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!gnt_valid && !instr_done && quiet) |=> !gnt_valid);

   assert_trace_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!gnt_valid && instr_done && int_mode < 2'd2 && quiet) |=> !gnt_sel[EXC_TRACE]);

   assert_no_trace_rte_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!gnt_valid && instr_done && instr_cls == ICLS_RTE && quiet) |=> !gnt_sel[EXC_TRACE]);

   assert_no_irq_ctrl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!gnt_valid && instr_done && instr_cls == ICLS_CTRL && quiet) |=> !gnt_sel[EXC_IRQ]);

   assert_no_irq_after_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_valid && gnt_sel[EXC_RESET] && gnt_ack && quiet) |=> !gnt_sel[EXC_IRQ]);

   assert_trap_vec_R10: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_sel[EXC_TRAP] |-> gnt_vec >= VEC_W'(VEC_TRAP_BASE));
endmodule

bind exc_arbiter exc_arbiter_chk #(
   .VEC_W        (VEC_W),
   .VEC_RESET    (VEC_RESET),
   .VEC_TRAP_BASE(VEC_TRAP_BASE)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .res_n      (res_n),
   .wdt_ovf    (wdt_ovf),
   .instr_done (instr_done),
   .instr_cls  (instr_cls),
   .int_mode   (int_mode),
   .gnt_ack    (gnt_ack),
   .gnt_valid  (gnt_valid),
   .gnt_sel    (gnt_sel),
   .gnt_vec    (gnt_vec)
);

// File: tb/exc_arbiter_tb.sv
module exc_arbiter_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       res_n = 1'b1, wdt_ovf = 1'b0, trace_en = 1'b0, irq_pend = 1'b0;
   logic       sleep_req = 1'b0, trap_exec = 1'b0, instr_done = 1'b0, gnt_ack = 1'b0;
   logic [1:0] trap_num = 2'd0, instr_cls = 2'd0, int_mode = 2'd0;
   logic       gnt_valid;
   logic [4:0] gnt_sel;
   logic [3:0] gnt_vec;

   int checks = 0;
   int failures = 0;

   logic       m_vld = 1'b1, m_dt = 1'b0, m_trap = 1'b0;
   logic [4:0] m_sel = 5'b00001;
   logic [3:0] m_vec = 4'd0;
   logic [1:0] m_num = 2'd0;

   always #10 clk = ~clk;

   exc_arbiter dut_i (
      .clk(clk), .rst_n(rst_n), .res_n(res_n), .wdt_ovf(wdt_ovf),
      .trace_en(trace_en), .irq_pend(irq_pend), .sleep_req(sleep_req),
      .trap_exec(trap_exec), .trap_num(trap_num), .instr_done(instr_done),
      .instr_cls(instr_cls), .int_mode(int_mode), .gnt_ack(gnt_ack),
      .gnt_valid(gnt_valid), .gnt_sel(gnt_sel), .gnt_vec(gnt_vec)
   );

   task automatic model_step();
      logic rst, ackv, bi, tr, ir, dtn, acc, trn, found;
      logic [1:0] numn;
      rst  = !res_n || wdt_ovf;
      ackv = gnt_ack && m_vld && !(m_sel[0] && !res_n);
      bi   = instr_done && !m_vld;
      dtn  = (m_dt && !(ackv && m_sel[3])) || sleep_req;
      acc  = trap_exec && (!m_trap || (ackv && m_sel[4]));
      trn  = (m_trap && !(ackv && m_sel[4])) || acc;
      numn = acc ? trap_num : m_num;
      tr   = trace_en && (int_mode >= 2'd2) && !(bi && instr_cls == 2'b01);
      ir   = irq_pend && !(bi && instr_cls == 2'b10) && !(ackv && m_sel[0]);
      if (rst) begin
         m_vld = 1'b1; m_sel = 5'b00001; m_vec = 4'd0; m_dt = 1'b0; m_trap = 1'b0;
      end else begin
         m_dt = dtn; m_trap = trn; m_num = numn;
         if (bi || ackv) begin
            found = 1'b1;
            if (tr)       begin m_sel = 5'b00010; m_vec = 4'd5; end
            else if (ir)  begin m_sel = 5'b00100; m_vec = 4'd7; end
            else if (dtn) begin m_sel = 5'b01000; m_vec = 4'd6; end
            else if (trn) begin m_sel = 5'b10000; m_vec = 4'd8 + {2'b00, numn}; end
            else found = 1'b0;
            if (found) m_vld = 1'b1;
            else if (ackv) begin m_vld = 1'b0; m_sel = 5'd0; m_vec = 4'd0; end
         end
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      model_step();
      @(negedge clk);
      checks++;
      if (gnt_valid !== m_vld || gnt_sel !== m_sel || gnt_vec !== m_vec) begin
         failures++;
         $display("FAIL %s model: actual v=%0b sel=%b vec=%0d expected v=%0b sel=%b vec=%0d",
                  m_sel[0] ? "R1" : "R4", gnt_valid, gnt_sel, gnt_vec, m_vld, m_sel, m_vec);
      end
      instr_done = 1'b0; gnt_ack = 1'b0; trap_exec = 1'b0; sleep_req = 1'b0; wdt_ovf = 1'b0;
   endtask

   task automatic expect_g(string tag, logic v, logic [4:0] s, logic [3:0] vec);
      checks++;
      if (gnt_valid !== v || gnt_sel !== s || gnt_vec !== vec) begin
         failures++;
         $display("FAIL %s: actual v=%0b sel=%b vec=%0d expected v=%0b sel=%b vec=%0d",
                  tag, gnt_valid, gnt_sel, gnt_vec, v, s, vec);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL R3 watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      expect_g("R1 reset state", 1, 5'b00001, 0);

      // R1: acknowledge ignored while the pin is low
      res_n = 0; gnt_ack = 1; cyc();
      expect_g("R1 ack under pin low", 1, 5'b00001, 0);
      // R7/R11: reset completion skips the interrupt
      res_n = 1; irq_pend = 1; gnt_ack = 1; cyc();
      expect_g("R7 no irq after reset ack", 0, 5'b00000, 0);
      instr_done = 1; instr_cls = 2'b00; cyc();
      expect_g("R3 irq at boundary", 1, 5'b00100, 7);
      // R2/R8: trap latched while a grant is held
      trap_exec = 1; trap_num = 2'd2; cyc(); cyc(); cyc();
      expect_g("R2 grant held", 1, 5'b00100, 7);
      irq_pend = 0; gnt_ack = 1; cyc();
      expect_g("R8 latched trap", 1, 5'b10000, 10);
      gnt_ack = 1; cyc();
      expect_g("R11 idle after drain", 0, 5'b00000, 0);
      trap_exec = 1; trap_num = 2'd3; cyc(); cyc();
      expect_g("R3 waits for boundary", 0, 5'b00000, 0);
      instr_done = 1; cyc();
      expect_g("R10 trap vector", 1, 5'b10000, 11);
      gnt_ack = 1; cyc();

      // R4: all four at once
      trace_en = 1; int_mode = 2; irq_pend = 1; sleep_req = 1;
      trap_exec = 1; trap_num = 2'd1; instr_done = 1; cyc();
      expect_g("R4 trace first", 1, 5'b00010, 5);
      trace_en = 0; gnt_ack = 1; cyc();
      expect_g("R4 irq second", 1, 5'b00100, 7);
      irq_pend = 0; gnt_ack = 1; cyc();
      expect_g("R9 direct transition", 1, 5'b01000, 6);
      gnt_ack = 1; cyc();
      expect_g("R4 trap last", 1, 5'b10000, 9);
      gnt_ack = 1; cyc();
      expect_g("R11 empty", 0, 5'b00000, 0);

      // R5: mode gate
      trace_en = 1; int_mode = 1; instr_done = 1; cyc();
      expect_g("R5 mode1 ignores trace", 0, 5'b00000, 0);
      int_mode = 0; instr_done = 1; cyc();
      expect_g("R5 mode0 ignores trace", 0, 5'b00000, 0);
      int_mode = 3; instr_done = 1; cyc();
      expect_g("R5 mode3 trace", 1, 5'b00010, 5);
      trace_en = 0; gnt_ack = 1; cyc();

      // R6: return-from-exception class
      trace_en = 1; int_mode = 2; instr_done = 1; instr_cls = 2'b01; cyc();
      expect_g("R6 no trace after rte", 0, 5'b00000, 0);
      instr_done = 1; instr_cls = 2'b00; cyc();
      expect_g("R6 trace next boundary", 1, 5'b00010, 5);
      trace_en = 0; gnt_ack = 1; cyc();

      // R7: control-register class
      irq_pend = 1; instr_done = 1; instr_cls = 2'b10; cyc();
      expect_g("R7 no irq after ctrl", 0, 5'b00000, 0);
      instr_done = 1; instr_cls = 2'b11; cyc();
      expect_g("R7 irq after other class", 1, 5'b00100, 7);

      // R1: watchdog replaces a grant and flushes a trap
      trap_exec = 1; trap_num = 2'd0; cyc();
      wdt_ovf = 1; cyc();
      expect_g("R1 watchdog preempts", 1, 5'b00001, 0);
      gnt_ack = 1; cyc();
      expect_g("R7 irq skipped after wdt reset", 0, 5'b00000, 0);
      irq_pend = 0; instr_done = 1; instr_cls = 2'b00; cyc();
      expect_g("R1 trap flushed", 0, 5'b00000, 0);

      // random phase against the model
      for (int n = 0; n < 4000; n++) begin
         res_n      = ($urandom % 200) != 0;
         wdt_ovf    = ($urandom % 150) == 0;
         trace_en   = ($urandom % 4) == 0;
         int_mode   = 2'($urandom);
         irq_pend   = ($urandom % 3) == 0;
         sleep_req  = ($urandom % 20) == 0;
         trap_exec  = ($urandom % 15) == 0;
         trap_num   = 2'($urandom);
         instr_done = ($urandom % 3) == 0;
         instr_cls  = 2'($urandom);
         gnt_ack    = ($urandom % 3) == 0;
         cyc();
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule